// File: doc/BRIEF.md
# Flash Status Register Guard

This block keeps the 16-bit status word of a serial NOR flash and decides whether a status write may change it. A write request carries a full 16-bit image. The block accepts it only when four conditions hold: the write-enable latch is set, the array is idle, no earlier status write is still pending, and the protect mode selected by two mode bits and the write-protect pin permits it. An accepted image is held in a staging register. It is committed when the array controller reports that programming is done. The commit also clears the write-enable latch.

Non-volatile fields are flops that keep their value across a power-cycle pulse. The synchronous reset loads the factory state. Three lock bits can only be set and never cleared. A lock-down protect mode holds until the next power cycle. A one-time mode holds permanently. A suspend flag is controlled only by suspend and resume strobes.

Top module: `sreg_guard`

## Requirements
- R1: After reset every status bit is 0. Bit order from bit 0 up is: busy, write-enable, protect field (bits 2..6), mode bit 0 (bit 7), mode bit 1 (bit 8), quad enable (bit 9), reserved (bit 10), lock bits (bits 11..13), complement (bit 14), suspend (bit 15).
- R2: With mode bits 00, a write is accepted when the write-enable latch is 1, whatever the level of `wp_n`. Without the latch the write is rejected and the status is unchanged.
- R3: With mode bits 01, a write is rejected while `wp_n` is low and accepted while `wp_n` is high and the latch is set.
- R4: With mode bits 10, every write is rejected. A power-cycle pulse returns the mode bits to 00 and keeps the other non-volatile fields.
- R5: With mode bits 11, every write is rejected, also after any number of power cycles.
- R6: Each lock bit is set by a committed write that carries a 1 in its position. A later write that carries 0 does not clear it.
- R7: Suspend is set by `susp_req` and cleared by `resume_req` or a power cycle. Status writes do not change it.
- R8: Write data in the busy and write-enable positions is ignored. The write-enable bit is 1 from `wel_set` until a commit. The busy bit is 1 while a write is pending and one cycle after `busy_in` is high.
- R9: Bit 10 always reads 0, whatever data is written to it.
- R10: `wr_accept` pulses in the cycle after an accepted request. A request while `busy_in` is high is rejected. The staged image reaches the status at the `prog_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to the factory state |
| pwr_cycle | input | 1 | One-cycle pulse modelling power removed and restored |
| wr_req | input | 1 | Status write request |
| wr_data | input | 16 | Image to write |
| wel_set | input | 1 | Sets the write-enable latch |
| wel_clr | input | 1 | Clears the write-enable latch |
| wp_n | input | 1 | Write-protect pin, active low |
| susp_req | input | 1 | Suspend instruction strobe |
| resume_req | input | 1 | Resume instruction strobe |
| busy_in | input | 1 | Array controller busy |
| prog_done | input | 1 | Array controller reports the status program finished |
| status_q | output | 16 | Current status word |
| wr_accept | output | 1 | Pulse: last request was accepted |

## Verification
The hardest state to reach is the permanent lock, because the bench can only enter it through a write that ends all further writes. The directed sequence therefore reaches it last. It first walks through the pin-controlled mode, the lock bits, suspend and the power-cycle lock-down, and sets the mode bits to 11 only at the end. Power cycles are then applied to show that the lock-down release does not extend to the permanent mode.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int PROT_W = 5;
  localparam int LB_N   = 3;
  localparam int B_BUSY = 0;
  localparam int B_WEL  = 1;
  localparam int B_PROT = 2;
  localparam int B_SRP0 = B_PROT + PROT_W;
  localparam int B_SRP1 = B_SRP0 + 1;
  localparam int B_QE   = B_SRP1 + 1;
  localparam int B_RSV  = B_QE + 1;
  localparam int B_LB   = B_RSV + 1;
  localparam int B_CMP  = B_LB + LB_N;
  localparam int B_SUS  = B_CMP + 1;
  localparam int SR_W   = B_SUS + 1;

  typedef enum logic [1:0] {
    PM_SOFT      = 2'b00,
    PM_PIN       = 2'b01,
    PM_UNTIL_PWR = 2'b10,
    PM_FOREVER   = 2'b11
  } prot_mode_e;
endpackage

// File: rtl/sreg_policy.sv
module sreg_policy
  import sreg_pkg::*;
(
  input  prot_mode_e mode,
  input  logic       wp_n,
  input  logic       wel,
  input  logic       busy,
  input  logic       wip,
  input  logic       wr_req,
  output logic       grant
);
  logic mode_ok;

  always_comb begin
    unique case (mode)
      PM_SOFT: mode_ok = 1'b1;
      PM_PIN:  mode_ok = wp_n;
      default: mode_ok = 1'b0;
    endcase
    grant = wr_req & wel & ~busy & ~wip & mode_ok;
  end
endmodule

// File: rtl/sreg_wel_ctl.sv
module sreg_wel_ctl (
  input  logic clk,
  input  logic rst,
  input  logic pwr_cycle,
  input  logic wel_set,
  input  logic wel_clr,
  input  logic commit,
  output logic wel_q
);
  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) wel_q <= 1'b0;
    else if (commit)      wel_q <= 1'b0;
    else if (wel_clr)     wel_q <= 1'b0;
    else if (wel_set)     wel_q <= 1'b1;
  end
endmodule

// File: rtl/sreg_nv_bank.sv
module sreg_nv_bank
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              grant,
  input  logic [PROT_W-1:0] wd_prot,
  input  logic [1:0]        wd_srp,
  input  logic              wd_qe,
  input  logic [LB_N-1:0]   wd_lb,
  input  logic              wd_cmp,
  input  logic              prog_done,
  input  logic              susp_req,
  input  logic              resume_req,
  output logic [SR_W-1:0]   nv_q,
  output logic              wip_q,
  output logic              commit
);
  logic [PROT_W-1:0] prot_q, st_prot;
  logic [1:0]        srp_q, st_srp;
  logic              qe_q, st_qe, cmp_q, st_cmp, sus_q;
  logic [LB_N-1:0]   lb_q, st_lb;

  assign commit = wip_q & prog_done & ~pwr_cycle;

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) begin
      wip_q <= 1'b0;
    end else if (grant) begin
      wip_q   <= 1'b1;
      st_prot <= wd_prot;
      st_srp  <= wd_srp;
      st_qe   <= wd_qe;
      st_lb   <= wd_lb;
      st_cmp  <= wd_cmp;
    end else if (commit) begin
      wip_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= '0;
      qe_q   <= 1'b0;
      cmp_q  <= 1'b0;
    end else if (commit) begin
      prot_q <= st_prot;
      qe_q   <= st_qe;
      cmp_q  <= st_cmp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                        srp_q <= 2'b00;
    else if (pwr_cycle && srp_q == PM_UNTIL_PWR)    srp_q <= 2'b00;
    else if (commit)                                srp_q <= st_srp;
  end

  for (genvar i = 0; i < LB_N; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)                   lb_q[i] <= 1'b0;
      else if (commit && st_lb[i]) lb_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_cycle) sus_q <= 1'b0;
    else if (resume_req)  sus_q <= 1'b0;
    else if (susp_req)    sus_q <= 1'b1;
  end

  always_comb begin
    nv_q                       = '0;
    nv_q[B_PROT +: PROT_W]     = prot_q;
    nv_q[B_SRP0]               = srp_q[0];
    nv_q[B_SRP1]               = srp_q[1];
    nv_q[B_QE]                 = qe_q;
    nv_q[B_LB +: LB_N]         = lb_q;
    nv_q[B_CMP]                = cmp_q;
    nv_q[B_SUS]                = sus_q;
  end

  // R6: a lock bit never returns to 0
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(lb_q) & ~lb_q) == '0));
  // R5: permanent mode never leaves
  a_r5_forever_holds: assert property (@(posedge clk) disable iff (rst)
    (srp_q == 2'b11) |=> (srp_q == 2'b11));
  // R4: lock-down only left through a power cycle
  a_r4_until_pwr_holds: assert property (@(posedge clk) disable iff (rst)
    (srp_q == 2'b10 && !pwr_cycle) |=> (srp_q == 2'b10));
  // R7: power cycle clears suspend
  a_r7_pwr_clears_sus: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle |=> !sus_q);
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_cycle,
  input  logic            wr_req,
  input  logic [15:0]     wr_data,
  input  logic            wel_set,
  input  logic            wel_clr,
  input  logic            wp_n,
  input  logic            susp_req,
  input  logic            resume_req,
  input  logic            busy_in,
  input  logic            prog_done,
  output logic [15:0]     status_q,
  output logic            wr_accept
);
  logic [SR_W-1:0] nv_q;
  logic            wel_q, wip_q, busy_q, grant, commit;
  prot_mode_e      mode;
  logic            unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[B_BUSY], wr_data[B_WEL], wr_data[B_RSV], wr_data[B_SUS]};
  assign mode = prot_mode_e'({nv_q[B_SRP1], nv_q[B_SRP0]});

  sreg_policy u_policy (
    .mode(mode), .wp_n(wp_n), .wel(wel_q), .busy(busy_in),
    .wip(wip_q), .wr_req(wr_req), .grant(grant)
  );

  sreg_wel_ctl u_wel (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .wel_set(wel_set),
    .wel_clr(wel_clr), .commit(commit), .wel_q(wel_q)
  );

  sreg_nv_bank u_bank (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .grant(grant),
    .wd_prot(wr_data[B_PROT +: PROT_W]),
    .wd_srp({wr_data[B_SRP1], wr_data[B_SRP0]}),
    .wd_qe(wr_data[B_QE]), .wd_lb(wr_data[B_LB +: LB_N]),
    .wd_cmp(wr_data[B_CMP]), .prog_done(prog_done),
    .susp_req(susp_req), .resume_req(resume_req),
    .nv_q(nv_q), .wip_q(wip_q), .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      wr_accept <= 1'b0;
    end else begin
      busy_q    <= busy_in;
      wr_accept <= grant;
    end
  end

  always_comb begin
    status_q         = nv_q;
    status_q[B_BUSY] = busy_q | wip_q;
    status_q[B_WEL]  = wel_q;
  end

  // R2: acceptance requires the latch in the cycle of the request
  a_r2_accept_needs_wel: assert property (@(posedge clk) disable iff (rst)
    wr_accept |-> $past(wel_q));
  // R3: pin low blocks in pin mode
  a_r3_pin_blocks: assert property (@(posedge clk) disable iff (rst)
    (wr_req && mode == PM_PIN && !wp_n) |=> !wr_accept);
  // R10: no acceptance while the array is busy
  a_r10_busy_rejects: assert property (@(posedge clk) disable iff (rst)
    (wr_req && busy_in) |=> !wr_accept);
  // R8: latch is clear once a pending write ends
  a_r8_wel_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(wip_q) |-> !wel_q);
  // R9: reserved bit reads 0
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_q[B_RSV] == 1'b0);
endmodule

// File: tb/sim_sreg_guard.sv
module sim_sreg_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_cycle = 1'b0, wr_req = 1'b0, wel_set = 1'b0, wel_clr = 1'b0;
  logic        wp_n = 1'b1, susp_req = 1'b0, resume_req = 1'b0;
  logic        busy_in = 1'b0, prog_done = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status_q;
  logic        wr_accept;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sreg_guard u0 (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .wr_req(wr_req),
    .wr_data(wr_data), .wel_set(wel_set), .wel_clr(wel_clr), .wp_n(wp_n),
    .susp_req(susp_req), .resume_req(resume_req), .busy_in(busy_in),
    .prog_done(prog_done), .status_q(status_q), .wr_accept(wr_accept)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic give_wel;
    wel_set = 1'b1; tick; wel_set = 1'b0;
  endtask

  task automatic try_write(input logic [15:0] d, input logic exp_acc, input string tag);
    wr_data = d; wr_req = 1'b1; tick; wr_req = 1'b0;
    chk(tag, {15'd0, wr_accept}, {15'd0, exp_acc});
  endtask

  task automatic finish_prog;
    prog_done = 1'b1; tick; prog_done = 1'b0;
  endtask

  task automatic pulse_pwr;
    pwr_cycle = 1'b1; tick; pwr_cycle = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset status", status_q, 16'h0000);
    chk("R1 reset accept", {15'd0, wr_accept}, 16'h0000);
  endtask

  task automatic t_soft_write;
    give_wel;
    chk("R8 wel bit set", status_q, 16'h0002);
    wp_n = 1'b0;
    try_write(16'h847F, 1'b1, "R2 soft mode accept with wp low");
    chk("R8 busy while pending", status_q, 16'h0003);
    finish_prog;
    chk("R9 R8 R10 committed image", status_q, 16'h007C);
    wp_n = 1'b1;
  endtask

  task automatic t_no_wel;
    try_write(16'h0000, 1'b0, "R2 reject without latch");
    chk("R2 status kept", status_q, 16'h007C);
  endtask

  task automatic t_busy;
    busy_in = 1'b1; tick;
    chk("R8 busy bit follows array", status_q, 16'h007D);
    give_wel;
    try_write(16'h0000, 1'b0, "R10 reject while busy");
    busy_in = 1'b0; tick;
    chk("R10 status kept", status_q, 16'h007E);
    wel_clr = 1'b1; tick; wel_clr = 1'b0;
  endtask

  task automatic t_pin_mode;
    give_wel; try_write(16'h0080, 1'b1, "R2 enter pin mode"); finish_prog;
    chk("R3 pin mode image", status_q, 16'h0080);
    wp_n = 1'b0; give_wel;
    try_write(16'h0084, 1'b0, "R3 wp low rejects");
    chk("R3 status kept", status_q, 16'h0082);
    wp_n = 1'b1;
    try_write(16'h0084, 1'b1, "R3 wp high accepts"); finish_prog;
    chk("R3 commit", status_q, 16'h0084);
  endtask

  task automatic t_lock_bits;
    give_wel; try_write(16'h0884, 1'b1, "R6 set lock1"); finish_prog;
    chk("R6 lock set", status_q, 16'h0884);
    give_wel; try_write(16'h0084, 1'b1, "R6 write zero"); finish_prog;
    chk("R6 lock kept", status_q, 16'h0884);
    give_wel; try_write(16'h0000, 1'b1, "R6 back to soft"); finish_prog;
    chk("R6 soft mode", status_q, 16'h0800);
  endtask

  task automatic t_suspend;
    susp_req = 1'b1; tick; susp_req = 1'b0;
    chk("R7 suspend set", status_q, 16'h8800);
    give_wel; try_write(16'h0000, 1'b1, "R7 write accept"); finish_prog;
    chk("R7 write keeps suspend", status_q, 16'h8800);
    resume_req = 1'b1; tick; resume_req = 1'b0;
    chk("R7 resume clears", status_q, 16'h0800);
    give_wel; try_write(16'h8000, 1'b1, "R7 write one"); finish_prog;
    chk("R7 write cannot set", status_q, 16'h0800);
    susp_req = 1'b1; tick; susp_req = 1'b0;
    pulse_pwr;
    chk("R7 power cycle clears", status_q, 16'h0800);
  endtask

  task automatic t_until_pwr;
    give_wel; try_write(16'h0124, 1'b1, "R4 enter lock-down"); finish_prog;
    chk("R4 lock-down image", status_q, 16'h0924);
    give_wel; try_write(16'h0000, 1'b0, "R4 write rejected");
    chk("R4 status kept", status_q, 16'h0926);
    pulse_pwr;
    chk("R4 power cycle releases", status_q, 16'h0824);
    give_wel; try_write(16'h0000, 1'b1, "R4 write after release"); finish_prog;
    chk("R4 commit after release", status_q, 16'h0800);
  endtask

  task automatic t_forever;
    give_wel; try_write(16'h0390, 1'b1, "R5 enter permanent"); finish_prog;
    chk("R5 permanent image", status_q, 16'h0B90);
    give_wel; try_write(16'h0000, 1'b0, "R5 write rejected");
    pulse_pwr; pulse_pwr;
    chk("R5 survives power cycles", status_q, 16'h0B90);
    give_wel; try_write(16'h0000, 1'b0, "R5 rejected after power cycle");
    chk("R5 status kept", status_q, 16'h0B92);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick;
    t_reset;
    t_soft_write;
    t_no_wel;
    t_busy;
    t_pin_mode;
    t_lock_bits;
    t_suspend;
    t_until_pwr;
    t_forever;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule